// File: doc/BRIEF.md
# Parallel Signed Array Multiplier

This block multiplies two N-bit two's complement operands and returns their full 2N-bit two's complement product in a single combinational pass. It has no clock and no state. It is meant to be placed inside a larger datapath that registers the inputs and outputs as it needs.

The signed product is rewritten so that every partial-product bit has positive weight. Each bit is the AND of one bit from each operand. The terms that pair the sign bit of one operand with a magnitude bit of the other are inverted. The product of the two sign bits is kept as it is. Two constant ones complete the matrix. An unsigned carry-save array then reduces the resulting rows, and a final carry-propagate adder turns the last two rows into the product. No sign correction follows the adder.

A parameter selects the form of the final adder: an explicit ripple chain of full adders, or a plain behavioural sum.

Top module: `bw_mult`

## Requirements
- R1: For every pair of N-bit two's complement operands, `prod` equals their mathematical product written as a 2N-bit two's complement number.
- R2: The most negative value times itself gives +2^(2N-2) (for N=4, -8 × -8 gives 0x40) with no overflow or sign flip.
- R3: -1 × -1 gives +1 (for N=4, operands 0xF and 0xF give 0x01).
- R4: When either operand is zero, `prod` is zero for any value of the other operand.
- R5: When both operands are nonzero, bit 2N-1 of `prod` equals the XOR of bit N-1 of the two operands.
- R6: Multiplying by +1 returns the other operand sign-extended to 2N bits.
- R7: Swapping the two operands leaves `prod` unchanged.
- R8: `prod` follows a change of the operands with no clock edge: the new value is present before the next rising edge of any surrounding clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | N | First signed operand, two's complement |
| op_y | input | N | Second signed operand, two's complement |
| prod | output | 2N | Signed product, two's complement |

## Verification
On every evaluation, the assertions check three things. The sum of the partial-product matrix with its constants matches the signed product. The carry-save array preserves the running sum of its rows. The final adder adds its two rows correctly, and the output sign agrees with the operand signs. Commutativity and the exact values of the named corner products can only be shown by the bench. The same holds for the absence of any clock dependence. The bench walks every operand pair and also applies swapped and single-step stimuli.

// File: rtl/bw_pkg.sv
package bw_pkg;
   // Sign-extend an N-bit operand into a W-bit container.
   function automatic logic [63:0] sext64(input logic [63:0] v, input int n);
      logic [63:0] r;
      r = v;
      for (int k = 0; k < 64; k++) begin
         if (k >= n) r[k] = v[n-1];
      end
      return r;
   endfunction
endpackage

// File: rtl/bw_ppgen.sv
module bw_ppgen #(
   parameter int N = 4,
   localparam int W = 2 * N,
   localparam int ROWS = N + 1
) (
   input  logic [N-1:0]               x,
   input  logic [N-1:0]               y,
   output logic [ROWS-1:0][W-1:0]     rows
);
   always_comb begin
      rows = '0;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            logic t;
            t = x[i] & y[j];
            // invert when exactly one factor is a sign bit
            if ((i == N-1) != (j == N-1)) t = ~t;
            rows[i][i+j] = t;
         end
      end
      rows[N][N]   = 1'b1;
      rows[N][W-1] = 1'b1;
   end

   logic [W-1:0] mtx_sum;
   logic [W-1:0] ref_prod;
   always_comb begin
      mtx_sum = '0;
      for (int r = 0; r < ROWS; r++) mtx_sum = mtx_sum + rows[r];
      ref_prod = W'(bw_pkg::sext64(64'(x), N) * bw_pkg::sext64(64'(y), N));
      p_matrix_sum_r1: assert (mtx_sum == ref_prod)
         else $error("partial-product matrix sum %h, expected %h", mtx_sum, ref_prod);
   end
endmodule

// File: rtl/bw_csa_array.sv
module bw_csa_array #(
   parameter int W = 8,
   parameter int ROWS = 5
) (
   input  logic [ROWS-1:0][W-1:0] rows,
   output logic [W-1:0]           sum_row,
   output logic [W-1:0]           cry_row
);
   generate
      if (ROWS < 3) begin : g_bad_rows
         $error("bw_csa_array needs at least three rows");
      end
   endgenerate

   logic [ROWS-2:0][W-1:0] ss;
   logic [ROWS-2:0][W-1:0] cc;

   assign ss[0] = rows[0];
   assign cc[0] = rows[1];

   generate
      for (genvar k = 1; k <= ROWS-2; k++) begin : g_stage
         logic [W-1:0] din;
         logic [W-1:0] maj;
         assign din   = rows[k+1];
         assign ss[k] = ss[k-1] ^ cc[k-1] ^ din;
         assign maj   = (ss[k-1] & cc[k-1]) | (ss[k-1] & din) | (cc[k-1] & din);
         assign cc[k] = {maj[W-2:0], 1'b0};
      end
   endgenerate

   assign sum_row = ss[ROWS-2];
   assign cry_row = cc[ROWS-2];

   logic [W-1:0] in_total;
   always_comb begin
      in_total = '0;
      for (int r = 0; r < ROWS; r++) in_total = in_total + rows[r];
      p_csa_keeps_sum_r1: assert (W'(sum_row + cry_row) == in_total)
         else $error("carry-save rows sum %h, inputs sum %h", W'(sum_row + cry_row), in_total);
   end
endmodule

// File: rtl/bw_cpa.sv
module bw_cpa #(
   parameter int W = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] s
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [W-1:0] cy;
         assign cy[0] = 1'b0;
         for (genvar g = 0; g < W; g++) begin : g_fa
            assign s[g] = a[g] ^ b[g] ^ cy[g];
            if (g < W-1) begin : g_carry
               assign cy[g+1] = (a[g] & b[g]) | (a[g] & cy[g]) | (b[g] & cy[g]);
            end
         end
      end else begin : g_behav
         assign s = a + b;
      end
   endgenerate

   always_comb begin
      p_cpa_sum_r1: assert (s == W'(a + b))
         else $error("final adder gave %h for %h + %h", s, a, b);
   end
endmodule

// File: rtl/bw_mult.sv
module bw_mult #(
   parameter int N = 4,
   parameter bit CPA_RIPPLE = 1'b1,
   localparam int W = 2 * N,
   localparam int ROWS = N + 1
) (
   input  logic [N-1:0] op_x,
   input  logic [N-1:0] op_y,
   output logic [W-1:0] prod
);
   generate
      if (N < 2 || N > 32) begin : g_bad_width
         $error("bw_mult: N must lie in 2..32");
      end
   endgenerate

   logic [ROWS-1:0][W-1:0] pp_rows;
   logic [W-1:0] sum_row;
   logic [W-1:0] cry_row;

   bw_ppgen #(.N(N)) u_ppgen (
      .x    (op_x),
      .y    (op_y),
      .rows (pp_rows)
   );

   bw_csa_array #(.W(W), .ROWS(ROWS)) u_csa (
      .rows    (pp_rows),
      .sum_row (sum_row),
      .cry_row (cry_row)
   );

   bw_cpa #(.W(W), .RIPPLE(CPA_RIPPLE)) u_cpa (
      .a (sum_row),
      .b (cry_row),
      .s (prod)
   );

   always_comb begin
      if (op_x != '0 && op_y != '0) begin
         p_sign_r5: assert (prod[W-1] == (op_x[N-1] ^ op_y[N-1]))
            else $error("product sign %b for operand signs %b %b", prod[W-1], op_x[N-1], op_y[N-1]);
      end
      if (op_x == '0 || op_y == '0) begin
         p_zero_r4: assert (prod == '0)
            else $error("nonzero product %h with a zero operand", prod);
      end
   end
endmodule

// File: tb/bw_mult_bench.sv
module bw_mult_bench;
   localparam int N = 4;
   localparam int W = 2 * N;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0] op_x = '0;
   logic [N-1:0] op_y = '0;
   logic [W-1:0] prod;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bw_mult #(.N(N)) u_bw_mult (
      .op_x (op_x),
      .op_y (op_y),
      .prod (prod)
   );

   function automatic int sval(input logic [N-1:0] v);
      return v[N-1] ? int'(v) - (1 << N) : int'(v);
   endfunction

   function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
      int p;
      p = sval(a) * sval(b);
      return W'(p);
   endfunction

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: x=%h y=%h got %h expected %h", tag, op_x, op_y, got, exp);
      end
   endtask

   // drive after the rising edge, sample at the falling edge
   task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b);
      @(posedge clk);
      #1;
      op_x = a;
      op_y = b;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R4: state right after reset, both operands zero
      @(negedge clk);
      check("R4 reset", prod, '0);

      // R1: exhaustive sweep against the behavioural model
      for (int a = 0; a < (1 << N); a++) begin
         for (int b = 0; b < (1 << N); b++) begin
            apply(N'(a), N'(b));
            check("R1 sweep", prod, ref_mul(N'(a), N'(b)));
         end
      end

      // R2: most negative squared
      apply(4'h8, 4'h8);
      check("R2 min*min", prod, 8'h40);

      // R3: -1 * -1
      apply(4'hF, 4'hF);
      check("R3 neg1*neg1", prod, 8'h01);

      // R4: zero against several patterns
      for (int b = 0; b < (1 << N); b += 5) begin
         apply(4'h0, N'(b));
         check("R4 zero x", prod, '0);
         apply(N'(b), 4'h0);
         check("R4 zero y", prod, '0);
      end

      // R5: sign bit against operand signs
      apply(4'h7, 4'h9);
      check("R5 sign pos*neg", {7'h0, prod[W-1]}, 8'h01);
      apply(4'hA, 4'hB);
      check("R5 sign neg*neg", {7'h0, prod[W-1]}, 8'h00);

      // R6: multiply by one returns sign-extended operand
      for (int a = 0; a < (1 << N); a += 3) begin
         apply(N'(a), 4'h1);
         check("R6 times one", prod, {{N{a[N-1]}}, N'(a)});
      end

      // R7: operand order does not matter
      for (int a = 1; a < (1 << N); a += 4) begin
         for (int b = 2; b < (1 << N); b += 5) begin
            logic [W-1:0] first;
            apply(N'(a), N'(b));
            first = prod;
            apply(N'(b), N'(a));
            check("R7 swap", prod, first);
         end
      end

      // R8: output settles without any clock edge
      @(posedge clk);
      #1;
      op_x = 4'h6;
      op_y = 4'hD;
      #1;
      check("R8 no clock", prod, 8'hEE);
      op_x = 4'h8;
      op_y = 4'h7;
      #1;
      check("R8 no clock", prod, 8'hC8);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule